// File: doc/BRIEF.md
# Stereo Zero-Data Detector

This block sits on the sample path into a stereo DAC. It watches the left and right sample words and raises a separate flag for each channel once that channel has carried nothing but all-zero words for a long qualifying stretch of frames. The default stretch is 8192 frames. The flags let downstream logic mute or power down an output that is carrying silence. Each flag drops as soon as its channel carries a non-zero word again.

Samples arrive as one frame per valid/ready handshake. `in_ready` is held high at all times, so the detector never applies back-pressure. Each cycle with `in_valid` high is one frame, and the words on `in_left` and `in_right` in that cycle belong to that frame.

Three control pins gate the detector:
- An enable pin and an active-low power-down pin clear the detector at once.
- A DAC run pin acts as a reset. It takes effect only when it stays low for a minimum number of frames.
- After a proper reset, the flags are held for a fixed number of frames past its release before they clear.

Counting always restarts one frame after every gate is open again.

Top module: `zero_watch`

## Requirements
- R1: While the detector is running, a channel's flag goes high on the frame that completes ZCOUNT (default 8192) consecutive counted all-zero frames on that channel. It is visible in the cycle after that frame's handshake and stays high while zero frames continue.
- R2: A high flag drops in the cycle after the first counted frame whose word on that channel is non-zero, with no delay.
- R3: While `det_enable` is low, both flags are low in the same cycle, and both channel counts are cleared.
- R4: While `pdn_n` is low (including straight after reset), both flags are low in the same cycle, and both channel counts are cleared.
- R5: Once `pdn_n`, `det_enable` and `dac_active` are all high, the first frame only arms the detector. Counting starts with the second frame.
- R6: If `dac_active` stays low for RST_QUAL (default 5) frames, the counts are cleared. The flags hold their value through the reset and keep it after `dac_active` returns high, then clear on the REL_DLY-th (default 6) frame after release. Counting re-arms after that, as in R5.
- R7: If `dac_active` is low for fewer than RST_QUAL frames, the low pulse is ignored. Counts and flags keep their values and counting resumes where it stopped.
- R8: `in_ready` is constantly high, and a frame is any cycle with `in_valid` high. Frames that arrive while the detector is held or reset have no effect on the counts.
- R9: A word counts as zero only when all SW bits, including the sign bit, are 0. The two channels are counted independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame valid; one frame per high cycle |
| in_ready | output | 1 | Always high; no back-pressure |
| in_left | input | SW | Left channel sample word |
| in_right | input | SW | Right channel sample word |
| det_enable | input | 1 | Detector enable; low forces flags low |
| pdn_n | input | 1 | Active-low power-down |
| dac_active | input | 1 | DAC powered and out of reset; low requests a reset |
| zflag_l | output | 1 | Left channel zero flag |
| zflag_r | output | 1 | Right channel zero flag |

## Verification
The hardest situation to reach is the tail of a proper DAC reset. Getting there needs both flags already high, `dac_active` held low across exactly RST_QUAL frames, and then a count of the frames after release. That shows the flags holding through the first REL_DLY-1 frames and clearing on the last one. The bench reaches it with a small configuration (ZCOUNT=16) and first saturates both channels with zeros. It then drives the low pulse one frame short of qualifying to exercise R7, and a full-length pulse with a pause in the reset state to exercise R6. A per-channel count computed in the bench predicts every flag.

// File: rtl/zw_pkg.sv
package zw_pkg;
  typedef enum logic [2:0] {
    ZW_IDLE = 3'd0,
    ZW_ARM  = 3'd1,
    ZW_RUN  = 3'd2,
    ZW_HOLD = 3'd3,
    ZW_RST  = 3'd4,
    ZW_REL  = 3'd5
  } zw_state_e;
endpackage

// File: rtl/zw_ctrl.sv
module zw_ctrl
  import zw_pkg::*;
#(
  parameter int RST_QUAL = 5,
  parameter int REL_DLY  = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame,
  input  logic      det_enable,
  input  logic      pdn_n,
  input  logic      dac_active,
  output logic      cnt_en,
  output logic      clr_cnt,
  output logic      clr_flag,
  output logic      gate_open,
  output zw_state_e st
);
  localparam int PMAX = (RST_QUAL > REL_DLY) ? RST_QUAL : REL_DLY;
  localparam int PW   = $clog2(PMAX + 1);
  localparam logic [PW-1:0] QUAL_LAST = PW'(RST_QUAL - 1);
  localparam logic [PW-1:0] REL_LAST  = PW'(REL_DLY - 1);

  zw_state_e     st_nx;
  logic [PW-1:0] phase, phase_nx;
  logic          rel_done;

  assign gate_open = pdn_n && det_enable;
  assign rel_done  = (st == ZW_REL) && dac_active && frame && (phase == REL_LAST);

  always_comb begin
    st_nx    = st;
    phase_nx = phase;
    if (!gate_open) begin
      st_nx    = ZW_IDLE;
      phase_nx = '0;
    end else begin
      unique case (st)
        ZW_IDLE: if (dac_active) st_nx = ZW_ARM;
        ZW_ARM: begin
          if (!dac_active) st_nx = ZW_IDLE;
          else if (frame)  st_nx = ZW_RUN;
        end
        ZW_RUN: begin
          if (!dac_active) begin
            st_nx    = ZW_HOLD;
            phase_nx = '0;
          end
        end
        ZW_HOLD: begin
          if (dac_active) st_nx = ZW_RUN;
          else if (frame) begin
            if (phase == QUAL_LAST) begin
              st_nx    = ZW_RST;
              phase_nx = '0;
            end else begin
              phase_nx = phase + 1'b1;
            end
          end
        end
        ZW_RST: begin
          if (dac_active) begin
            st_nx    = ZW_REL;
            phase_nx = '0;
          end
        end
        ZW_REL: begin
          if (!dac_active) begin
            st_nx    = ZW_RST;
            phase_nx = '0;
          end else if (frame) begin
            if (phase == REL_LAST) begin
              st_nx    = ZW_ARM;
              phase_nx = '0;
            end else begin
              phase_nx = phase + 1'b1;
            end
          end
        end
        default: st_nx = ZW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ZW_IDLE;
      phase <= '0;
    end else begin
      st    <= st_nx;
      phase <= phase_nx;
    end
  end

  assign cnt_en   = frame && gate_open && dac_active && (st == ZW_RUN);
  assign clr_cnt  = !gate_open || (st == ZW_IDLE) || (st == ZW_RST);
  assign clr_flag = !gate_open || (st == ZW_IDLE) || rel_done;
endmodule

// File: rtl/zw_chan.sv
module zw_chan #(
  parameter int SW     = 24,
  parameter int ZCOUNT = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          clr_cnt,
  input  logic          clr_flag,
  input  logic [SW-1:0] sample,
  output logic          flag
);
  localparam int CW = (ZCOUNT > 2) ? $clog2(ZCOUNT) : 1;
  localparam logic [CW-1:0] TERM = CW'(ZCOUNT - 1);

  logic [CW-1:0] cnt;
  logic          is_zero;

  assign is_zero = (sample == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr_cnt) begin
      cnt <= '0;
    end else if (cnt_en) begin
      if (!is_zero)         cnt <= '0;
      else if (cnt != TERM) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (clr_flag) begin
      flag <= 1'b0;
    end else if (cnt_en) begin
      if (!is_zero)          flag <= 1'b0;
      else if (cnt == TERM)  flag <= 1'b1;
    end
  end
endmodule

// File: rtl/zero_watch.sv
module zero_watch
  import zw_pkg::*;
#(
  parameter int SW       = 24,
  parameter int ZCOUNT   = 8192,
  parameter int RST_QUAL = 5,
  parameter int REL_DLY  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  input  logic          det_enable,
  input  logic          pdn_n,
  input  logic          dac_active,
  output logic          zflag_l,
  output logic          zflag_r
);
  localparam int NCH = 2;

  zw_state_e     st;
  logic          frame, cnt_en, clr_cnt, clr_flag, gate_open;
  logic [SW-1:0] smp [NCH];
  logic [NCH-1:0] flag_q;

  assign in_ready = 1'b1;
  assign frame    = in_valid && in_ready;
  assign smp[0]   = in_left;
  assign smp[1]   = in_right;

  zw_ctrl #(.RST_QUAL(RST_QUAL), .REL_DLY(REL_DLY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame(frame), .det_enable(det_enable),
    .pdn_n(pdn_n), .dac_active(dac_active), .cnt_en(cnt_en),
    .clr_cnt(clr_cnt), .clr_flag(clr_flag), .gate_open(gate_open), .st(st)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zw_chan #(.SW(SW), .ZCOUNT(ZCOUNT)) u_chan (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_cnt(clr_cnt),
      .clr_flag(clr_flag), .sample(smp[c]), .flag(flag_q[c])
    );
  end

  assign zflag_l = flag_q[0] && gate_open;
  assign zflag_r = flag_q[1] && gate_open;
endmodule

// File: rtl/zero_watch_chk.sv
module zero_watch_chk
  import zw_pkg::*;
#(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [SW-1:0] in_left,
  input logic          det_enable,
  input logic          pdn_n,
  input logic          dac_active,
  input logic          zflag_l,
  input logic          zflag_r,
  input logic [1:0]    flag_q,
  input zw_state_e     st
);
  p_rise_after_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zflag_l) |-> $past(in_valid && (in_left == '0)));

  p_drop_on_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ZW_RUN && dac_active && pdn_n && det_enable && in_valid && in_left != '0) |=> !zflag_l);

  p_enable_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !det_enable |-> (!zflag_l && !zflag_r));

  p_pdn_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |-> (!zflag_l && !zflag_r));

  p_hold_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ZW_HOLD && pdn_n && det_enable) |=> $stable(flag_q));

  p_arm_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ZW_ARM) |=> !$rose(flag_q[0]));
endmodule

bind zero_watch zero_watch_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
  .det_enable(det_enable), .pdn_n(pdn_n), .dac_active(dac_active),
  .zflag_l(zflag_l), .zflag_r(zflag_r), .flag_q(flag_q), .st(st)
);

// File: tb/zero_watch_bench.sv
module zero_watch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int ZC = 16;
  localparam int RQ = 5;
  localparam int RD = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_left = '0, in_right = '0;
  logic          det_enable = 1'b0, pdn_n = 1'b0, dac_active = 1'b0;
  logic          zflag_l, zflag_r;

  int n_run = 0, n_fail = 0;
  int m_l = 0, m_r = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_watch #(.SW(SW), .ZCOUNT(ZC), .RST_QUAL(RQ), .REL_DLY(RD)) u_zero_watch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .det_enable(det_enable),
    .pdn_n(pdn_n), .dac_active(dac_active), .zflag_l(zflag_l), .zflag_r(zflag_r)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // one frame; if model is set, bench counts advance per requirement R1/R2
  task automatic frame(input logic [SW-1:0] l, input logic [SW-1:0] r, input bit model);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0; in_left = '0; in_right = '0;
    if (model) begin
      m_l = (l == '0) ? ((m_l < ZC) ? m_l + 1 : ZC) : 0;
      m_r = (r == '0) ? ((m_r < ZC) ? m_r + 1 : ZC) : 0;
    end
  endtask

  task automatic mframe(input logic [SW-1:0] l, input logic [SW-1:0] r, input string req);
    frame(l, r, 1'b1);
    chk(zflag_l, m_l >= ZC, req);
    chk(zflag_r, m_r >= ZC, req);
  endtask

  task automatic arm_restart();
    frame('0, '0, 1'b0);
    m_l = 0; m_r = 0;
    chk(zflag_l, 1'b0, "R5 arm frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(zflag_l, 1'b0, "R4 reset state");
    chk(zflag_r, 1'b0, "R4 reset state");
    chk(in_ready, 1'b1, "R8 ready");
    // frames while powered down do nothing
    for (int i = 0; i < ZC + 2; i++) frame('0, '0, 1'b0);
    chk(zflag_l, 1'b0, "R4 powered down");

    pdn_n = 1'b1; det_enable = 1'b1; dac_active = 1'b1;
    @(negedge clk);
    arm_restart();
    // R1: rise exactly at ZC-th zero frame
    for (int i = 0; i < ZC + 3; i++) mframe('0, '0, "R1 rise");

    // R2/R9: every single bit, sign included, breaks the run
    for (int b = 0; b < SW; b++) begin
      mframe(SW'(1) << b, '0, "R2 R9 left bit");
      for (int i = 0; i < ZC; i++) mframe('0, '0, "R1 refill");
      mframe('0, SW'(1) << b, "R2 R9 right bit");
      for (int i = 0; i < ZC; i++) mframe('0, '0, "R1 refill");
    end
    // break position sweep
    for (int p = 1; p < ZC; p++) begin
      for (int i = 0; i < p; i++) mframe('0, '0, "R1 sweep");
      mframe(8'h80, 8'h01, "R2 sweep");
    end
    for (int i = 0; i < ZC; i++) mframe('0, '0, "R1 refill");
    chk(zflag_l, 1'b1, "R1 both high");

    // R3: enable low clears at once
    det_enable = 1'b0; #1;
    chk(zflag_l, 1'b0, "R3 immediate");
    chk(zflag_r, 1'b0, "R3 immediate");
    @(negedge clk);
    frame('0, '0, 1'b0);
    chk(zflag_l, 1'b0, "R3 held low");
    det_enable = 1'b1;
    @(negedge clk);
    arm_restart();
    for (int i = 0; i < ZC; i++) mframe('0, '0, "R3 R5 recount");

    // R4: power-down low clears at once
    pdn_n = 1'b0; #1;
    chk(zflag_r, 1'b0, "R4 immediate");
    @(negedge clk);
    frame('0, '0, 1'b0);
    chk(zflag_r, 1'b0, "R4 held low");
    pdn_n = 1'b1;
    @(negedge clk);
    arm_restart();
    for (int i = 0; i < ZC; i++) mframe('0, '0, "R4 R5 recount");

    // R7: short low pulse ignored
    dac_active = 1'b0;
    @(negedge clk);
    for (int i = 0; i < RQ - 1; i++) begin
      frame(8'h55, 8'h55, 1'b0);
      chk(zflag_l, 1'b1, "R7 pulse hold");
    end
    dac_active = 1'b1;
    @(negedge clk);
    mframe('0, '0, "R7 resumed");
    mframe(8'h01, '0, "R7 R2 resumed running");
    for (int i = 0; i < ZC; i++) mframe('0, '0, "R1 refill");

    // R6: qualified reset, flags held until REL_DLY frames after release
    dac_active = 1'b0;
    @(negedge clk);
    for (int i = 0; i < RQ + 2; i++) begin
      frame(8'h11, 8'h22, 1'b0);
      chk(zflag_l, 1'b1, "R6 held in reset");
      chk(zflag_r, 1'b1, "R6 held in reset");
    end
    dac_active = 1'b1;
    @(negedge clk);
    for (int i = 1; i <= RD; i++) begin
      frame('0, '0, 1'b0);
      chk(zflag_l, (i < RD), "R6 release delay");
      chk(zflag_r, (i < RD), "R6 release delay");
    end
    arm_restart();
    for (int i = 0; i < ZC; i++) mframe('0, '0, "R6 R5 recount after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule